// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and a full calendar date in binary-coded fields. It is fed by a one-cycle enable pulse, `tick_i`, that fires at the 32.768 kHz oscillator rate in the system clock domain. A two-stage prescaler turns these pulses into a 1.024 kHz internal tick and then into one advance per second. The second advance ripples through minutes, hours, day of week, date, month, two-digit year, century and millennium. Month lengths and the Gregorian leap-year rule are applied for every year from 0000 to 9999, and the count wraps back to 0000.

A host loads any single field through a write strobe, a field address and a data byte. Every field is presented on its own output at all times. The hour is kept internally as 0..23. It is shown and written either in that 24-hour form or in a 12-hour form with a PM flag, chosen by `mode12_i`. A one-cycle strobe marks each advance of the seconds field, and an alarm comparator downstream can use it.

Top module: `cal_rtc`

## Requirements
- R1: After reset the outputs read 2000-01-01 00:00:00 (millennium 2, century 0, year 0, month 1, date 1), day of week 1, sec_stb_o 0 and pm_o 0.
- R2: The seconds field advances once for every DIV*TPS pulses of tick_i, which is 32*1024 = 32768 with the default parameters. Cycles without tick_i do not count.
- R3: Seconds and minutes run 0..59 and hours run 0..23 internally. Each field wraps to 0 and carries to the next field up.
- R4: Date runs from 1 to the month's length: 30 for months 4, 6, 9 and 11, and 31 for months 1, 3, 5, 7, 8, 10 and 12. It then wraps to 1 and the month advances. Month 12 wraps to 1.
- R5: February has 29 days when the full year is a leap year, and 28 days otherwise. A year with a nonzero two-digit part is leap when that part is divisible by 4. A year whose two-digit part is 0 is leap when millennium*10+century is divisible by 4.
- R6: Year wraps from 99 to 0 and carries into century. Century wraps from 9 to 0 and carries into millennium. 9999-12-31 23:59:59 advances to 0000-01-01 00:00:00.
- R7: Day of week runs 1..7. It advances only at the midnight rollover, and wraps from 7 to 1.
- R8: With mode12_i=0, hour_o shows 0..23 and pm_o is 0. With mode12_i=1, internal hour 0 shows as 12 with pm_o=0, hours 1..11 show unchanged with pm_o=0, 12 shows as 12 with pm_o=1, and 13..23 show as hour-12 with pm_o=1. The display follows mode12_i without waiting for a clock edge.
- R9: A write with wr_en_i high loads wr_data_i into the field at wr_addr_i: 0 second, 1 minute, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 century, 8 millennium. The hour data takes the current display form, with the hour in bits 4:0 and, in 12-hour mode, PM in bit 5. Addresses 9..15 change no field. Written values must be legal for their field.
- R10: Any write clears the prescaler, so the next second advance comes a full DIV*TPS pulses later. A write in the same cycle as a would-be second advance wins, and the advance is dropped.
- R11: sec_stb_o is high for exactly the one cycle in which the new seconds value first appears, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| mode12_i | input | 1 | 1 selects 12-hour display/write form |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 4 | Field address |
| wr_data_i | input | 7 | Field write data |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hour in the selected form |
| pm_o | output | 1 | PM flag in 12-hour form |
| dow_o | output | 3 | Day of week 1..7 |
| date_o | output | 5 | Day of month |
| month_o | output | 4 | Month 1..12 |
| year_o | output | 7 | Year within century 0..99 |
| century_o | output | 4 | Century digit |
| millennium_o | output | 4 | Millennium digit |
| sec_stb_o | output | 1 | Seconds-advance strobe |

## Verification
The calendar is loaded just before a rollover and then advanced by one second. The starting points cover a plain seconds step, an hour carry, the ends of 30-day and 31-day months, February in common years, in years divisible by 4, in century years that are leap and not leap, and the year, century, millennium and 9999 wraps. This separates month-length errors from leap-rule errors and from carry-chain errors. Directed cases cover the 11-to-12 hour step in 12-hour form in both halves of the day, switching the display form on a fixed internal hour, the day-of-week wrap, writes that land part-way through the prescaler count or on the advance cycle itself, and writes to unused addresses.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int unsigned SEC_W  = 6;
  localparam int unsigned MIN_W  = 6;
  localparam int unsigned HOUR_W = 5;
  localparam int unsigned DOW_W  = 3;
  localparam int unsigned DATE_W = 5;
  localparam int unsigned MON_W  = 4;
  localparam int unsigned YEAR_W = 7;
  localparam int unsigned DIG_W  = 4;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    FLD_SEC  = 4'd0,
    FLD_MIN  = 4'd1,
    FLD_HOUR = 4'd2,
    FLD_DOW  = 4'd3,
    FLD_DATE = 4'd4,
    FLD_MON  = 4'd5,
    FLD_YEAR = 4'd6,
    FLD_CEN  = 4'd7,
    FLD_MIL  = 4'd8
  } fld_e;

  // Gregorian: century years use the full century number
  function automatic logic is_leap(input logic [YEAR_W-1:0] yr,
                                   input logic [DIG_W-1:0]  cen,
                                   input logic [DIG_W-1:0]  mil);
    logic [6:0] c;
    c = 7'(mil) * 7'd10 + 7'(cen);
    if (yr != '0) return ((yr & 7'd3) == 7'd0);
    return ((c & 7'd3) == 7'd0);
  endfunction

  function automatic logic [DATE_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                  input logic leap);
    case (mon)
      4'd2:                      month_len = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
      default:                   month_len = 5'd31;
    endcase
  endfunction

  // returns {pm, hour}
  function automatic logic [HOUR_W:0] hour_to_disp(input logic [HOUR_W-1:0] h24,
                                                   input logic mode12);
    if (!mode12)       return {1'b0, h24};
    if (h24 == 5'd0)   return {1'b0, 5'd12};
    if (h24 < 5'd12)   return {1'b0, h24};
    if (h24 == 5'd12)  return {1'b1, 5'd12};
    return {1'b1, h24 - 5'd12};
  endfunction

  function automatic logic [HOUR_W-1:0] hour_from_disp(input logic [HOUR_W:0] d,
                                                       input logic mode12);
    logic [HOUR_W-1:0] h;
    h = d[HOUR_W-1:0];
    if (!mode12)     return h;
    if (h == 5'd12)  return d[HOUR_W] ? 5'd12 : 5'd0;
    return d[HOUR_W] ? h + 5'd12 : h;
  endfunction
endpackage

// File: rtl/cal_rtc_field.sv
module cal_rtc_field #(
  parameter int unsigned   W       = 6,
  parameter logic [W-1:0]  RST_VAL = '0,
  parameter logic [W-1:0]  LOW_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic         wrap_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (ld_i)   q_o <= ld_val_i;
    else if (inc_i)  q_o <= wrap_i ? LOW_VAL : q_o + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_presc.sv
module cal_rtc_presc #(
  parameter int unsigned DIV = 32,
  parameter int unsigned TPS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_adv_o
);
  localparam int unsigned LO_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned HI_W = (TPS > 1) ? $clog2(TPS) : 1;

  logic ms_tick;

  generate
    if (DIV > 1) begin : g_lo
      logic [LO_W-1:0] lo_q;
      logic            lo_end;
      assign lo_end = (lo_q == LO_W'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      lo_q <= '0;
        else if (clr_i)   lo_q <= '0;
        else if (tick_i)  lo_q <= lo_end ? '0 : lo_q + 1'b1;
      end
      assign ms_tick = tick_i & lo_end;
    end else begin : g_lo_bypass
      assign ms_tick = tick_i;
    end

    if (TPS > 1) begin : g_hi
      logic [HI_W-1:0] hi_q;
      logic            hi_end;
      assign hi_end = (hi_q == HI_W'(TPS - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       hi_q <= '0;
        else if (clr_i)    hi_q <= '0;
        else if (ms_tick)  hi_q <= hi_end ? '0 : hi_q + 1'b1;
      end
      assign sec_adv_o = ms_tick & hi_end & ~clr_i;
    end else begin : g_hi_bypass
      assign sec_adv_o = ms_tick & ~clr_i;
    end
  endgenerate
endmodule

// File: rtl/cal_rtc_tod.sv
module cal_rtc_tod
  import cal_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              mode12_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic              day_adv_o,
  output logic              sec_stb_o
);
  logic sec_wrap, min_wrap, hour_wrap;
  logic min_inc, hour_inc;
  logic [HOUR_W-1:0] hour_ld;

  assign sec_wrap  = (sec_o  == 6'd59);
  assign min_wrap  = (min_o  == 6'd59);
  assign hour_wrap = (hour_o == 5'd23);
  assign min_inc   = adv_i & sec_wrap;
  assign hour_inc  = min_inc & min_wrap;
  assign day_adv_o = hour_inc & hour_wrap;
  assign hour_ld   = hour_from_disp(wr_data_i[HOUR_W:0], mode12_i);

  cal_rtc_field #(.W(SEC_W)) u_sec (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_SEC),
    .ld_val_i (wr_data_i[SEC_W-1:0]),
    .inc_i    (adv_i),
    .wrap_i   (sec_wrap),
    .q_o      (sec_o)
  );

  cal_rtc_field #(.W(MIN_W)) u_min (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_MIN),
    .ld_val_i (wr_data_i[MIN_W-1:0]),
    .inc_i    (min_inc),
    .wrap_i   (min_wrap),
    .q_o      (min_o)
  );

  cal_rtc_field #(.W(HOUR_W)) u_hour (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_HOUR),
    .ld_val_i (hour_ld),
    .inc_i    (hour_inc),
    .wrap_i   (hour_wrap),
    .q_o      (hour_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_stb_o <= 1'b0;
    else         sec_stb_o <= adv_i;
  end
endmodule

// File: rtl/cal_rtc_date.sv
module cal_rtc_date
  import cal_rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              day_adv_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DOW_W-1:0]  dow_o,
  output logic [DATE_W-1:0] date_o,
  output logic [MON_W-1:0]  month_o,
  output logic [YEAR_W-1:0] year_o,
  output logic [DIG_W-1:0]  century_o,
  output logic [DIG_W-1:0]  millennium_o
);
  logic leap;
  logic dow_wrap, date_wrap, mon_wrap, yr_wrap, cen_wrap, mil_wrap;
  logic mon_inc, yr_inc, cen_inc, mil_inc;

  assign leap      = is_leap(year_o, century_o, millennium_o);
  assign dow_wrap  = (dow_o >= 3'd7);
  assign date_wrap = (date_o >= month_len(month_o, leap));
  assign mon_wrap  = (month_o >= 4'd12);
  assign yr_wrap   = (year_o >= 7'd99);
  assign cen_wrap  = (century_o >= 4'd9);
  assign mil_wrap  = (millennium_o >= 4'd9);
  assign mon_inc   = day_adv_i & date_wrap;
  assign yr_inc    = mon_inc & mon_wrap;
  assign cen_inc   = yr_inc & yr_wrap;
  assign mil_inc   = cen_inc & cen_wrap;

  cal_rtc_field #(.W(DOW_W), .RST_VAL(3'd1), .LOW_VAL(3'd1)) u_dow (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_DOW),
    .ld_val_i (wr_data_i[DOW_W-1:0]),
    .inc_i    (day_adv_i),
    .wrap_i   (dow_wrap),
    .q_o      (dow_o)
  );

  cal_rtc_field #(.W(DATE_W), .RST_VAL(5'd1), .LOW_VAL(5'd1)) u_date (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_DATE),
    .ld_val_i (wr_data_i[DATE_W-1:0]),
    .inc_i    (day_adv_i),
    .wrap_i   (date_wrap),
    .q_o      (date_o)
  );

  cal_rtc_field #(.W(MON_W), .RST_VAL(4'd1), .LOW_VAL(4'd1)) u_mon (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_MON),
    .ld_val_i (wr_data_i[MON_W-1:0]),
    .inc_i    (mon_inc),
    .wrap_i   (mon_wrap),
    .q_o      (month_o)
  );

  cal_rtc_field #(.W(YEAR_W)) u_year (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_YEAR),
    .ld_val_i (wr_data_i[YEAR_W-1:0]),
    .inc_i    (yr_inc),
    .wrap_i   (yr_wrap),
    .q_o      (year_o)
  );

  cal_rtc_field #(.W(DIG_W)) u_cen (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_CEN),
    .ld_val_i (wr_data_i[DIG_W-1:0]),
    .inc_i    (cen_inc),
    .wrap_i   (cen_wrap),
    .q_o      (century_o)
  );

  cal_rtc_field #(.W(DIG_W), .RST_VAL(4'd2)) u_mil (
    .clk_i, .rst_ni,
    .ld_i     (wr_en_i && wr_addr_i == FLD_MIL),
    .ld_val_i (wr_data_i[DIG_W-1:0]),
    .inc_i    (mil_inc),
    .wrap_i   (mil_wrap),
    .q_o      (millennium_o)
  );
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int unsigned DIV = 32,
  parameter int unsigned TPS = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode12_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic              pm_o,
  output logic [DOW_W-1:0]  dow_o,
  output logic [DATE_W-1:0] date_o,
  output logic [MON_W-1:0]  month_o,
  output logic [YEAR_W-1:0] year_o,
  output logic [DIG_W-1:0]  century_o,
  output logic [DIG_W-1:0]  millennium_o,
  output logic              sec_stb_o
);
  logic              sec_adv;
  logic              day_adv;
  logic [HOUR_W-1:0] hour24;

  cal_rtc_presc #(.DIV(DIV), .TPS(TPS)) u_presc (
    .clk_i, .rst_ni,
    .tick_i    (tick_i),
    .clr_i     (wr_en_i),
    .sec_adv_o (sec_adv)
  );

  cal_rtc_tod u_tod (
    .clk_i, .rst_ni,
    .adv_i     (sec_adv),
    .mode12_i  (mode12_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour24),
    .day_adv_o (day_adv),
    .sec_stb_o (sec_stb_o)
  );

  cal_rtc_date u_date (
    .clk_i, .rst_ni,
    .day_adv_i    (day_adv),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .dow_o        (dow_o),
    .date_o       (date_o),
    .month_o      (month_o),
    .year_o       (year_o),
    .century_o    (century_o),
    .millennium_o (millennium_o)
  );

  assign {pm_o, hour_o} = hour_to_disp(hour24, mode12_i);
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode12_i,
  input logic              wr_en_i,
  input logic [SEC_W-1:0]  sec_o,
  input logic [MIN_W-1:0]  min_o,
  input logic [HOUR_W-1:0] hour_o,
  input logic              pm_o,
  input logic [DOW_W-1:0]  dow_o,
  input logic [DATE_W-1:0] date_o,
  input logic [MON_W-1:0]  month_o,
  input logic [YEAR_W-1:0] year_o,
  input logic [DIG_W-1:0]  century_o,
  input logic [DIG_W-1:0]  millennium_o,
  input logic              sec_stb_o
);
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (sec_stb_o || $stable(sec_o)));  // R2

  AST_CLOCK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o < 6'd60) && (min_o < 6'd60));  // R3

  AST_DATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (date_o >= 5'd1) &&
    (date_o <= month_len(month_o, is_leap(year_o, century_o, millennium_o))));  // R4

  AST_FEB29_LEAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (month_o == 4'd2 && date_o == 5'd29) |-> is_leap(year_o, century_o, millennium_o));  // R5

  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dow_o >= 3'd1) && (dow_o <= 3'd7));  // R7

  AST_HOUR12_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode12_i |-> (hour_o >= 5'd1 && hour_o <= 5'd12));  // R8

  AST_HOUR24_NO_PM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode12_i |-> (!pm_o && hour_o < 5'd24));  // R8

  AST_STB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb_o |-> (($past(sec_o) == 6'd59) ? (sec_o == 6'd0)
                                           : (sec_o == $past(sec_o) + 6'd1)));  // R11

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_stb_o |=> !sec_stb_o);  // R11
endmodule

bind cal_rtc cal_rtc_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode12_i     (mode12_i),
  .wr_en_i      (wr_en_i),
  .sec_o        (sec_o),
  .min_o        (min_o),
  .hour_o       (hour_o),
  .pm_o         (pm_o),
  .dow_o        (dow_o),
  .date_o       (date_o),
  .month_o      (month_o),
  .year_o       (year_o),
  .century_o    (century_o),
  .millennium_o (millennium_o),
  .sec_stb_o    (sec_stb_o)
);

// File: tb/cal_rtc_tb_top.sv
`timescale 1ns/1ps
module cal_rtc_tb_top;
  import cal_rtc_pkg::*;

  localparam int unsigned P_DIV = 2;
  localparam int unsigned P_TPS = 2;
  localparam int          TOT   = P_DIV * P_TPS;

  typedef struct packed { int mil, cen, yr, mon, dt, hr, mn, sc; } cal_t;
  typedef struct packed { cal_t st; cal_t ex; } vec_t;

  // each entry: start point, state one second later (24-hour form)
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{'{2,0,0,1,1,0,0,0},      '{2,0,0,1,1,0,0,1}},     // plain step
    '{'{2,0,23,6,15,12,34,59}, '{2,0,23,6,15,12,35,0}}, // minute carry
    '{'{2,0,23,9,30,10,59,59}, '{2,0,23,9,30,11,0,0}},  // hour carry
    '{'{2,0,23,1,31,23,59,59}, '{2,0,23,2,1,0,0,0}},    // 31-day month
    '{'{2,0,23,4,30,23,59,59}, '{2,0,23,5,1,0,0,0}},    // 30-day month
    '{'{2,0,23,11,30,23,59,59},'{2,0,23,12,1,0,0,0}},
    '{'{2,0,23,2,28,23,59,59}, '{2,0,23,3,1,0,0,0}},    // common Feb
    '{'{2,0,24,2,28,23,59,59}, '{2,0,24,2,29,0,0,0}},   // leap Feb
    '{'{2,0,24,2,29,23,59,59}, '{2,0,24,3,1,0,0,0}},
    '{'{1,9,0,2,28,23,59,59},  '{1,9,0,3,1,0,0,0}},     // 1900 not leap
    '{'{2,0,0,2,28,23,59,59},  '{2,0,0,2,29,0,0,0}},    // 2000 leap
    '{'{2,1,0,2,28,23,59,59},  '{2,1,0,3,1,0,0,0}},     // 2100 not leap
    '{'{2,0,23,12,31,23,59,59},'{2,0,24,1,1,0,0,0}},    // year carry
    '{'{2,0,99,12,31,23,59,59},'{2,1,0,1,1,0,0,0}},     // century carry
    '{'{1,9,99,12,31,23,59,59},'{2,0,0,1,1,0,0,0}},     // millennium carry
    '{'{9,9,99,12,31,23,59,59},'{0,0,0,1,1,0,0,0}}      // 9999 wrap
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic mode12 = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;

  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  mn;
  logic [HOUR_W-1:0] hr;
  logic              pm;
  logic [DOW_W-1:0]  dow;
  logic [DATE_W-1:0] dt;
  logic [MON_W-1:0]  mon;
  logic [YEAR_W-1:0] yr;
  logic [DIG_W-1:0]  cen;
  logic [DIG_W-1:0]  mil;
  logic              stb;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cal_rtc #(.DIV(P_DIV), .TPS(P_TPS)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .mode12_i     (mode12),
    .wr_en_i      (we),
    .wr_addr_i    (addr),
    .wr_data_i    (wdata),
    .sec_o        (sec),
    .min_o        (mn),
    .hour_o       (hr),
    .pm_o         (pm),
    .dow_o        (dow),
    .date_o       (dt),
    .month_o      (mon),
    .year_o       (yr),
    .century_o    (cen),
    .millennium_o (mil),
    .sec_stb_o    (stb)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic cal_t now();
    return '{int'(mil), int'(cen), int'(yr), int'(mon), int'(dt),
             int'(hr), int'(mn), int'(sec)};
  endfunction

  task automatic chk_cal(input string req, input cal_t exp);
    cal_t act;
    act = now();
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s calendar: actual=%p expected=%p", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input int d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = DATA_W'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load(input cal_t c);
    wr(FLD_DATE, 1);
    wr(FLD_MIL, c.mil);
    wr(FLD_CEN, c.cen);
    wr(FLD_YEAR, c.yr);
    wr(FLD_MON, c.mon);
    wr(FLD_DATE, c.dt);
    wr(FLD_HOUR, c.hr);
    wr(FLD_MIN, c.mn);
    wr(FLD_SEC, c.sc);
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.ex.mil != v.st.mil || v.ex.cen != v.st.cen || v.ex.yr != v.st.yr) return "R6";
    if (v.st.mon == 2) return "R5";
    if (v.ex.mon != v.st.mon) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cal_t c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_cal("R1", '{2,0,0,1,1,0,0,0});
    chk("R1", "dow", int'(dow), 1);
    chk("R1", "stb", int'(stb), 0);
    chk("R1", "pm", int'(pm), 0);

    // R2 idle cycles without tick do nothing
    repeat (10) @(negedge clk);
    chk("R2", "sec idle", int'(sec), 0);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].st);
      ticks(TOT - 1);
      chk("R2", "sec before last tick", int'(sec), VEC[i].st.sc);
      ticks(1);
      chk_cal(tag_of(VEC[i]), VEC[i].ex);
      chk("R11", "stb high", int'(stb), 1);
      @(negedge clk);
      chk("R11", "stb low", int'(stb), 0);
    end

    // R8 12-hour display
    mode12 = 1'b1;
    wr(FLD_MON, 9);
    wr(FLD_DATE, 10);
    wr(FLD_HOUR, 11);          // 11 AM
    wr(FLD_MIN, 59);
    wr(FLD_SEC, 59);
    ticks(TOT);
    chk("R8", "hour 11am->", int'(hr), 12);
    chk("R8", "pm after 11am", int'(pm), 1);
    chk("R8", "date noon", int'(dt), 10);
    wr(FLD_HOUR, 32 + 11);     // 11 PM
    wr(FLD_MIN, 59);
    wr(FLD_SEC, 59);
    ticks(TOT);
    chk("R8", "hour 11pm->", int'(hr), 12);
    chk("R8", "pm after 11pm", int'(pm), 0);
    chk("R4", "date midnight", int'(dt), 11);
    wr(FLD_HOUR, 12);          // 12 AM
    chk("R8", "12am hour", int'(hr), 12);
    chk("R8", "12am pm", int'(pm), 0);
    @(negedge clk); mode12 = 1'b0; #1;
    chk("R8", "12am in 24h", int'(hr), 0);
    @(negedge clk); mode12 = 1'b1;
    wr(FLD_HOUR, 32 + 1);      // 1 PM
    chk("R8", "1pm hour", int'(hr), 1);
    chk("R8", "1pm pm", int'(pm), 1);
    @(negedge clk); mode12 = 1'b0; #1;
    chk("R8", "1pm in 24h", int'(hr), 13);
    chk("R8", "24h pm", int'(pm), 0);

    // R7 day of week
    wr(FLD_DOW, 7);
    wr(FLD_HOUR, 23);
    wr(FLD_MIN, 59);
    wr(FLD_SEC, 59);
    ticks(TOT);
    chk("R7", "dow 7->1", int'(dow), 1);
    wr(FLD_DOW, 3);
    wr(FLD_HOUR, 23);
    wr(FLD_MIN, 59);
    wr(FLD_SEC, 59);
    ticks(TOT);
    chk("R7", "dow 3->4", int'(dow), 4);
    wr(FLD_HOUR, 10);
    wr(FLD_MIN, 59);
    wr(FLD_SEC, 59);
    ticks(TOT);
    chk("R7", "dow off midnight", int'(dow), 4);

    // R10 write clears prescaler
    wr(FLD_SEC, 10);
    ticks(TOT - 1);
    wr(FLD_MIN, 5);
    ticks(TOT - 1);
    chk("R10", "sec after clear", int'(sec), 10);
    ticks(1);
    chk("R10", "sec full period", int'(sec), 11);
    // write on the advance cycle
    ticks(TOT - 1);
    @(negedge clk);
    tick = 1'b1; we = 1'b1; addr = FLD_SEC; wdata = DATA_W'(20);
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    chk("R10", "write wins", int'(sec), 20);
    chk("R10", "no stb on write", int'(stb), 0);
    ticks(TOT - 1);
    chk("R10", "sec after collide", int'(sec), 20);
    ticks(1);
    chk("R10", "sec next", int'(sec), 21);

    // R9 unused address
    c0 = now();
    wr(4'd12, 7);
    chk_cal("R9", c0);
    chk("R9", "dow unused addr", int'(dow), 4);
    wr(FLD_YEAR, 42);
    chk("R9", "year write", int'(yr), 42);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule